// File: doc/BRIEF.md
# Window Watchdog with Violation Counter

This block supervises a host processor through a window watchdog. Once it is enabled, it opens with an optional start-up window. After that the timer alternates between two windows. In the closed window a service pulse is early, so it counts as a violation. In the open window a service pulse is accepted and the cycle starts again. Violations add up against a programmable tolerance. When the tolerance is exceeded, a latched fault is raised.

The fault can be steered to a reset-request output, which gives a pulse of programmable length, and to a level interrupt output. Time is measured in ticks of an external 1 ms strobe. The reset pulse is measured in clock cycles, through a parameter that gives the number of cycles in 100 µs. All configuration arrives as plain input fields. Service and tick are single-cycle strobes with no handshake, so no back-pressure exists anywhere.

Top module: `window_watchdog`

## Requirements
- R1: The watchdog runs only while both `cfg_wd_en` and `wd_pin_en` are 1. In every other case `wd_fault`, `wd_irq` and `wd_rst_req` stay 0 and unserviced time has no effect. After reset all three outputs are 0.
- R2: A window programmed with code c lasts 1 + floor((c·863 + 127) / 255) ticks: 1 tick at code 0 and 864 ticks at code 255. A window loaded at a clock edge expires at the edge that sees its last tick.
- R3: On enable, a non-zero start-up multiplier m opens a start-up window of m times the open-window length. With m = 0 the first closed window starts at once.
- R4: A service pulse in the start-up window ends it without a violation and starts a closed window. Expiry of the start-up window counts one violation and then starts a closed window.
- R5: A service pulse in the closed window counts one violation and restarts the closed window.
- R6: Expiry of the closed window opens the open window. A service pulse in the open window clears the violation count and starts a new closed window.
- R7: If the open window expires without service, one violation is counted and a new closed window starts.
- R8: The fault is raised at the edge of the violation that takes the count above `cfg_max_viol`, where 0 means the first violation faults. The fault then stays latched and the timer stops. Regular service never faults.
- R9: `wd_irq` is a registered level equal to the fault AND `cfg_route_irq`.
- R10: When the fault is raised with `cfg_route_rst` = 1, `wd_rst_req` goes high in the same cycle as the fault. It stays high for U·CYC_PER_100US cycles, where U is given by `cfg_rst_dly` codes 0..7 as 2, 10, 100, 160, 200, 700, 1000 and 2000. With `cfg_route_rst` = 0 no pulse is produced.
- R11: Dropping either enable clears the fault, the interrupt, the reset pulse and the count at the next edge. Re-enabling starts again from the start-up step.
- R12: A service pulse that arrives in the same cycle as a window's final tick is judged in the window it arrived in, ahead of the expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | 1 ms time-base strobe |
| svc_pulse | input | 1 | Service strobe from the host |
| wd_pin_en | input | 1 | Hardware enable pin |
| cfg_wd_en | input | 1 | Register enable bit |
| cfg_close | input | 8 | Closed-window length code |
| cfg_open | input | 8 | Open-window length code |
| cfg_max_viol | input | VIOL_W | Tolerated violation count |
| cfg_start_mult | input | MULT_W | Start-up window multiplier |
| cfg_route_rst | input | 1 | Steer the fault to the reset request |
| cfg_route_irq | input | 1 | Steer the fault to the interrupt |
| cfg_rst_dly | input | 3 | Reset pulse length code |
| wd_fault | output | 1 | Latched watchdog fault |
| wd_irq | output | 1 | Interrupt level |
| wd_rst_req | output | 1 | Reset request pulse |

## Verification
The bench sets CYC_PER_100US to 2. This makes even the longest reset pulse 4000 cycles, so every reset-delay code, including code 7, can be measured to the exact cycle. Most scenarios drive the tick on every clock, so exact edge counts from enable to fault can be compared against the window formula, including code 255. A divide-by-3 tick pattern exercises the case where service and tick do not line up. The bench model holds its own window and remaining-tick state. This lets it aim service pulses at the start-up, closed and open windows, and at the very last tick of a window.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [2:0] {
    WD_IDLE  = 3'd0,
    WD_START = 3'd1,
    WD_SHUT  = 3'd2,
    WD_OPEN  = 3'd3,
    WD_TRIP  = 3'd4
  } wd_state_e;

  localparam int unsigned WIN_W = 10;  // holds up to 864 ticks

  // Linear map of an 8-bit code onto 1..864 ticks, rounded.
  function automatic logic [WIN_W-1:0] win_ticks(input logic [7:0] code);
    logic [17:0] prod;
    logic [17:0] quot;
    prod = 18'(code) * 18'd863 + 18'd127;
    quot = prod / 18'd255;
    return WIN_W'(quot + 18'd1);
  endfunction

  // Reset pulse length in units of 100 us.
  function automatic logic [10:0] rst_units(input logic [2:0] code);
    logic [10:0] u;
    case (code)
      3'd0: u = 11'd2;
      3'd1: u = 11'd10;
      3'd2: u = 11'd100;
      3'd3: u = 11'd160;
      3'd4: u = 11'd200;
      3'd5: u = 11'd700;
      3'd6: u = 11'd1000;
      default: u = 11'd2000;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/wdg_tick_timer.sv
module wdg_tick_timer #(
  parameter int unsigned TMR_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic             expire
);

  logic [TMR_W-1:0] cnt_q;

  assign expire = tick && (cnt_q == TMR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run)            cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (tick && cnt_q != '0) cnt_q <= cnt_q - TMR_W'(1);
  end

  // R2: each tick outside a load takes exactly one off the remaining time
  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && tick && cnt_q > TMR_W'(1)) |=> (cnt_q == $past(cnt_q) - TMR_W'(1)));

endmodule

// File: rtl/wdg_viol_ctr.sv
module wdg_viol_ctr #(
  parameter int unsigned VIOL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kill,
  input  logic              clr,
  input  logic              inc,
  input  logic [VIOL_W-1:0] max_viol,
  output logic              trip,
  output logic              fault
);

  localparam int unsigned CNT_W = VIOL_W + 1;

  logic [CNT_W-1:0] count_q;

  // count + 1 > max is the same as count >= max
  assign trip = inc && !fault && (count_q >= CNT_W'(max_viol));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      fault   <= 1'b0;
    end else if (kill) begin
      count_q <= '0;
      fault   <= 1'b0;
    end else begin
      if (clr)                         count_q <= '0;
      else if (inc && count_q != '1)   count_q <= count_q + CNT_W'(1);
      if (trip)                        fault   <= 1'b1;
    end
  end

  // R5: the count only ever steps up by one or returns to zero
  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != $past(count_q)) |-> (count_q == $past(count_q) + CNT_W'(1) || count_q == '0));

  // R8: a new fault only follows a count that had reached the limit
  assert_trip_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> ($past(count_q) >= CNT_W'($past(max_viol))));

endmodule

// File: rtl/wdg_rst_stretch.sv
module wdg_rst_stretch #(
  parameter int unsigned CYC_PER_100US = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kill,
  input  logic       start,
  input  logic [2:0] dly_code,
  output logic       pulse
);
  import wdg_pkg::*;

  localparam int unsigned LONGEST = 2000 * CYC_PER_100US;
  localparam int unsigned CW      = $clog2(LONGEST + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len;

  assign len = CW'(rst_units(dly_code)) * CW'(CYC_PER_100US);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (kill) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (start) begin
      cnt_q <= len;
      pulse <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
      pulse <= (cnt_q != CW'(1));
    end
  end

  // R10: the pulse never outlives its counter
  assert_pulse_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && cnt_q == CW'(1) && !start && !kill) |=> !pulse);

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog #(
  parameter int unsigned VIOL_W        = 3,
  parameter int unsigned MULT_W        = 3,
  parameter int unsigned CYC_PER_100US = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic              svc_pulse,
  input  logic              wd_pin_en,
  input  logic              cfg_wd_en,
  input  logic [7:0]        cfg_close,
  input  logic [7:0]        cfg_open,
  input  logic [VIOL_W-1:0] cfg_max_viol,
  input  logic [MULT_W-1:0] cfg_start_mult,
  input  logic              cfg_route_rst,
  input  logic              cfg_route_irq,
  input  logic [2:0]        cfg_rst_dly,
  output logic              wd_fault,
  output logic              wd_irq,
  output logic              wd_rst_req
);
  import wdg_pkg::*;

  localparam int unsigned TMR_W = WIN_W + MULT_W;

  wd_state_e        st_q, st_d;
  logic             run;
  logic             ld;
  logic [TMR_W-1:0] ld_val;
  logic [TMR_W-1:0] close_len, open_len, start_len;
  logic             expire;
  logic             v_inc, v_clr, trip;

  assign run       = cfg_wd_en && wd_pin_en;
  assign close_len = TMR_W'(win_ticks(cfg_close));
  assign open_len  = TMR_W'(win_ticks(cfg_open));
  assign start_len = open_len * TMR_W'(cfg_start_mult);

  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = close_len;
    v_inc  = 1'b0;
    v_clr  = 1'b0;
    if (!run) begin
      st_d = WD_IDLE;
    end else begin
      case (st_q)
        WD_IDLE: begin
          ld = 1'b1;
          if (cfg_start_mult != '0) begin
            st_d   = WD_START;
            ld_val = start_len;
          end else begin
            st_d = WD_SHUT;
          end
        end
        WD_START: begin
          if (svc_pulse) begin
            st_d = WD_SHUT; ld = 1'b1;
          end else if (expire) begin
            v_inc = 1'b1; st_d = WD_SHUT; ld = 1'b1;
          end
        end
        WD_SHUT: begin
          if (svc_pulse) begin
            v_inc = 1'b1; ld = 1'b1;
          end else if (expire) begin
            st_d = WD_OPEN; ld = 1'b1; ld_val = open_len;
          end
        end
        WD_OPEN: begin
          if (svc_pulse) begin
            v_clr = 1'b1; st_d = WD_SHUT; ld = 1'b1;
          end else if (expire) begin
            v_inc = 1'b1; st_d = WD_SHUT; ld = 1'b1;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WD_IDLE;
    else        st_q <= (run && trip) ? WD_TRIP : st_d;
  end

  wdg_tick_timer #(.TMR_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (tick_ms),
    .load     (ld),
    .load_val (ld_val),
    .expire   (expire)
  );

  wdg_viol_ctr #(.VIOL_W(VIOL_W)) u_viol (
    .clk      (clk),
    .rst_n    (rst_n),
    .kill     (!run),
    .clr      (v_clr),
    .inc      (v_inc),
    .max_viol (cfg_max_viol),
    .trip     (trip),
    .fault    (wd_fault)
  );

  wdg_rst_stretch #(.CYC_PER_100US(CYC_PER_100US)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .kill     (!run),
    .start    (trip && cfg_route_rst),
    .dly_code (cfg_rst_dly),
    .pulse    (wd_rst_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wd_irq <= 1'b0;
    else        wd_irq <= run && cfg_route_irq && (trip || wd_fault);
  end

  // R11: losing either enable clears every output at the next edge
  assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!wd_fault && !wd_irq && !wd_rst_req));

  // R9: the interrupt level never appears without the fault
  assert_irq_needs_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |-> wd_fault);

  // R10: a reset request only starts together with a new fault
  assert_rst_on_trip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst_req) |-> $rose(wd_fault));

  // R8: the fault is latched while enabled
  assert_fault_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_fault && run) |=> wd_fault);

endmodule

// File: tb/test_window_watchdog.sv
`timescale 1ns/1ps
module test_window_watchdog;

  localparam int CYC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0, svc_pulse = 1'b0, wd_pin_en = 1'b0, cfg_wd_en = 1'b0;
  logic [7:0] cfg_close = 8'd1, cfg_open = 8'd2;
  logic [2:0] cfg_max_viol = 3'd0, cfg_start_mult = 3'd0, cfg_rst_dly = 3'd0;
  logic cfg_route_rst = 1'b1, cfg_route_irq = 1'b1;
  logic wd_fault, wd_irq, wd_rst_req;

  window_watchdog #(.VIOL_W(3), .MULT_W(3), .CYC_PER_100US(CYC)) i_window_watchdog (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .svc_pulse(svc_pulse),
    .wd_pin_en(wd_pin_en), .cfg_wd_en(cfg_wd_en), .cfg_close(cfg_close),
    .cfg_open(cfg_open), .cfg_max_viol(cfg_max_viol), .cfg_start_mult(cfg_start_mult),
    .cfg_route_rst(cfg_route_rst), .cfg_route_irq(cfg_route_irq), .cfg_rst_dly(cfg_rst_dly),
    .wd_fault(wd_fault), .wd_irq(wd_irq), .wd_rst_req(wd_rst_req));

  always #10 clk = ~clk;  // 50 MHz

  int n_checks = 0, n_fail = 0;
  string cur_req = "R1";
  bit tick_all = 1'b0;
  bit done = 1'b0;

  // ---------------- behavioural reference model ----------------
  // m_st: 0 idle, 1 start-up, 2 closed, 3 open, 4 fault
  int m_st = 0, m_rem = 0, m_cnt = 0, m_rcyc = 0;
  bit m_fault = 0, m_irq = 0, m_rst = 0;

  function automatic int ticks_of(input int code);
    return 1 + (code * 863 + 127) / 255;
  endfunction

  function automatic int units_of(input int code);
    case (code)
      0: return 2;     1: return 10;   2: return 100;  3: return 160;
      4: return 200;   5: return 700;  6: return 1000; default: return 2000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_rem = 0; m_cnt = 0; m_rcyc = 0; m_fault = 0; m_irq = 0; m_rst = 0;
    end else begin
      bit run, fin, viol, load, trip;
      int nval;
      run = cfg_wd_en && wd_pin_en;
      fin = tick_ms && (m_rem == 1);
      viol = 0; load = 0; trip = 0; nval = 0;
      if (!run) begin
        m_st = 0; m_rem = 0; m_cnt = 0; m_fault = 0; m_rcyc = 0;
      end else begin
        case (m_st)
          0: begin
            load = 1;
            if (cfg_start_mult != 0) begin m_st = 1; nval = ticks_of(cfg_open) * cfg_start_mult; end
            else begin m_st = 2; nval = ticks_of(cfg_close); end
          end
          1: if (svc_pulse) begin m_st = 2; load = 1; nval = ticks_of(cfg_close); end
             else if (fin) begin viol = 1; m_st = 2; load = 1; nval = ticks_of(cfg_close); end
          2: if (svc_pulse) begin viol = 1; load = 1; nval = ticks_of(cfg_close); end
             else if (fin) begin m_st = 3; load = 1; nval = ticks_of(cfg_open); end
          3: if (svc_pulse) begin m_cnt = 0; m_st = 2; load = 1; nval = ticks_of(cfg_close); end
             else if (fin) begin viol = 1; m_st = 2; load = 1; nval = ticks_of(cfg_close); end
          default: ;
        endcase
        if (load) m_rem = nval;
        else if (tick_ms && m_rem > 0) m_rem = m_rem - 1;
        if (viol) begin
          if (m_cnt >= cfg_max_viol && !m_fault) trip = 1;
          if (m_cnt < 15) m_cnt = m_cnt + 1;
        end
        if (trip) begin
          m_fault = 1; m_st = 4;
          if (cfg_route_rst) m_rcyc = units_of(cfg_rst_dly) * CYC;
          else if (m_rcyc > 0) m_rcyc = m_rcyc - 1;
        end else if (m_rcyc > 0) m_rcyc = m_rcyc - 1;
      end
      m_irq = run && cfg_route_irq && m_fault;
      m_rst = (m_rcyc != 0);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      n_checks++;
      if ({wd_fault, wd_irq, wd_rst_req} !== {m_fault, m_irq, m_rst}) begin
        n_fail++;
        $display("FAIL %s model compare @%0t: actual fault/irq/rst=%b%b%b expected %b%b%b",
                 cur_req, $time, wd_fault, wd_irq, wd_rst_req, m_fault, m_irq, m_rst);
      end
    end
  end

  // tick generator: every cycle or once every three cycles
  initial begin
    int tc;
    tc = 0;
    forever begin
      @(posedge clk); #5;
      tick_ms = tick_all ? 1'b1 : (tc == 2);
      tc = (tc + 1) % 3;
    end
  end

  task automatic cyc();
    @(posedge clk); #5;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse();
    svc_pulse = 1'b1; cyc(); svc_pulse = 1'b0;
  endtask

  task automatic serve_open();
    while (m_st != 3) cyc();
    pulse();
  endtask

  task automatic enable();
    cfg_wd_en = 1'b1; wd_pin_en = 1'b1;
  endtask

  task automatic disable_wd();
    cfg_wd_en = 1'b0; cyc(); cyc();
  endtask

  task automatic time_to_fault(output int n);
    n = 0;
    while (!wd_fault && n < 5000) begin cyc(); n++; end
  endtask

  task automatic pulse_width(output int n);
    n = 0;
    while (wd_rst_req && n < 5000) begin cyc(); n++; end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    int n;
    repeat (4) cyc();
    cur_req = "R1";
    chk("R1 reset fault", wd_fault, 0);
    chk("R1 reset rst", wd_rst_req, 0);
    rst_n = 1'b1; cyc();

    // R1: one enable alone does nothing
    cfg_wd_en = 1'b1; wd_pin_en = 1'b0;
    repeat (100) cyc();
    chk("R1 pin low", wd_fault, 0);
    cfg_wd_en = 1'b0; wd_pin_en = 1'b1;
    repeat (60) cyc();
    chk("R1 reg low", wd_fault, 0);
    wd_pin_en = 1'b0; cyc();

    tick_all = 1'b1;
    // R3: start-up window of 2 x 8 ticks, then its expiry faults (max 0)
    cur_req = "R3";
    cfg_start_mult = 3'd2; cfg_max_viol = 3'd0;
    enable(); time_to_fault(n);
    chk("R3 start-up length", n, 17);

    // R11: disable clears, re-enable restarts start-up
    cur_req = "R11";
    cfg_wd_en = 1'b0; cyc();
    chk("R11 fault cleared", wd_fault, 0);
    chk("R11 irq cleared", wd_irq, 0);
    enable(); time_to_fault(n);
    chk("R11 restart timing", n, 17);
    disable_wd();

    // R2: no start-up; closed 4 ticks then open 8 ticks expire
    cur_req = "R2";
    cfg_start_mult = 3'd0;
    enable(); time_to_fault(n);
    chk("R2 short windows", n, 13);
    disable_wd();
    cfg_close = 8'd255;
    enable(); time_to_fault(n);
    chk("R2 code 255", n, 1 + 864 + 8);
    disable_wd();
    cfg_close = 8'd1;

    // R4: service inside start-up is not a violation
    cur_req = "R4";
    cfg_start_mult = 3'd2; cfg_max_viol = 3'd0;
    enable(); repeat (3) cyc();
    pulse();
    chk("R4 start-up service", wd_fault, 0);
    serve_open(); serve_open();
    chk("R4 then serviced", wd_fault, 0);
    disable_wd();

    // R5: closed-window service counts
    cur_req = "R5";
    cfg_start_mult = 3'd0; cfg_max_viol = 3'd1;
    enable(); repeat (2) cyc();
    pulse();
    chk("R5 first early service", wd_fault, 0);
    pulse();
    chk("R5 second early service", wd_fault, 1);
    disable_wd();

    // R6: open-window service clears the count
    cur_req = "R6";
    enable(); repeat (2) cyc();
    pulse();
    serve_open(); cyc();
    pulse();
    chk("R6 count cleared", wd_fault, 0);
    pulse();
    chk("R6 count rebuilt", wd_fault, 1);
    disable_wd();

    // R7: open-window expiries, tolerate two
    cur_req = "R7";
    cfg_max_viol = 3'd2;
    enable(); time_to_fault(n);
    chk("R7 third missed window", n, 1 + 3 * 12);

    // R8: fault stays latched
    cur_req = "R8";
    repeat (100) cyc();
    chk("R8 latched", wd_fault, 1);
    disable_wd();
    cfg_max_viol = 3'd0; tick_all = 1'b0;
    enable();
    for (int k = 0; k < 6; k++) serve_open();
    chk("R8 regular service", wd_fault, 0);
    disable_wd();
    tick_all = 1'b1;

    // R10: reset pulse lengths
    cur_req = "R10";
    cfg_rst_dly = 3'd1;
    enable(); time_to_fault(n); pulse_width(n);
    chk("R10 code 1 width", n, 10 * CYC);
    disable_wd();
    cfg_rst_dly = 3'd7;
    enable(); time_to_fault(n); pulse_width(n);
    chk("R10 code 7 width", n, 2000 * CYC);
    disable_wd();
    cfg_route_rst = 1'b0;
    enable(); time_to_fault(n);
    chk("R10 unrouted no pulse", wd_rst_req, 0);

    // R9: interrupt follows routing while faulted
    cur_req = "R9";
    cfg_route_irq = 1'b0; cyc(); cyc();
    chk("R9 irq unrouted", wd_irq, 0);
    cfg_route_irq = 1'b1; cyc();
    chk("R9 irq routed", wd_irq, 1);
    disable_wd();
    cfg_route_rst = 1'b1;

    // R12: service on the final tick of a window
    cur_req = "R12";
    enable();
    while (!(m_st == 3 && m_rem == 1)) cyc();
    pulse();
    chk("R12 last-tick open service", wd_fault, 0);
    while (!(m_st == 2 && m_rem == 1)) cyc();
    pulse();
    chk("R12 last-tick closed service", wd_fault, 1);
    disable_wd();

    finish_run();
  end

endmodule